// File: doc/BRIEF.md
# Interrupt Mask and Condition Unit

This block turns the upper half of an engine's 64-bit status word into one level-sensitive interrupt line. The block keeps a 16-bit interrupt mask. Software can see the conditions in two forms: a raw view, which is the status word moved down by sixteen places, and a masked view, which is the raw view limited to the bits the mask enables. The interrupt output is high while any masked condition bit is set.

Software reaches the block through a request/response register port that carries word offsets. Three offsets act differently for reads and for writes:

- Offset 0x8 reads the mask and writes the mask.
- Offset 0x9 reads the raw view. A write to 0x9 sets mask bits (OR).
- Offset 0xA reads the masked view. A write to 0xA keeps only the selected mask bits (AND).

Back-pressure works as follows:

- A request is taken on a clock where `req_valid_i` and `req_ready_o` are both high.
- Only reads produce a response. The response is held in a one-entry register with `rsp_valid_o` until `rsp_ready_i` is seen.
- `req_ready_o` is low only while a response is held and the consumer is not taking it in that cycle.

A separate engine-reset pulse clears the mask and the condition registers.

Top module: `irq_cond_unit`

## Requirements
- R1: A read at offset 0x9 returns the raw condition: bits 47:0 hold status bits 63:16, as sampled at the previous clock. Bits 63:48 read zero.
- R2: A read at offset 0xA returns the masked condition in bits 47:32. This is raw bits 47:32 ANDed with the mask. All other bits read zero.
- R3: `irq_o` is high exactly when (raw bits 47:32 AND mask) is non-zero. A status change or a mask change shows on `irq_o` one clock after it is sampled or accepted.
- R4: A write at offset 0x8 replaces the mask with write-data bits 47:32. A read at 0x8 returns the mask in bits 47:32, with zeros elsewhere. Only these 16 mask bits exist.
- R5: A write at offset 0x9 ORs write-data bits 47:32 into the mask.
- R6: A write at offset 0xA ANDs write-data bits 47:32 into the mask.
- R7: A high `eng_reset_i` clears the mask and the raw condition at the next clock. It takes priority over a mask write accepted in the same cycle.
- R8: A write at any offset other than 0x8, 0x9 or 0xA leaves the mask unchanged. A read at any such offset returns zero.
- R9: `req_ready_o` equals (not `rsp_valid_o`) or `rsp_ready_i`. An accepted read raises `rsp_valid_o` on the next clock. The response data stays stable until `rsp_ready_i` is seen. Writes produce no response.
- R10: After `rst_n` is low, the mask and the raw condition are zero, `irq_o` is low and `rsp_valid_o` is low.
- R11: In the condition bits, these status bits map as follows:
  - status bit 63 (invalid command) becomes condition bit 47;
  - status bit 58 (no acknowledge) becomes bit 42;
  - status bit 57 (data request) becomes bit 41;
  - status bit 56 (command complete) becomes bit 40.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| eng_reset_i | input | 1 | Engine reset pulse; clears mask and conditions |
| status_i | input | 64 | Engine status word |
| req_valid_i | input | 1 | Register request valid |
| req_ready_o | output | 1 | Register request can be taken |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_off_i | input | 4 | Register word offset |
| req_wdata_i | input | 64 | Write data |
| rsp_valid_o | output | 1 | Read response valid |
| rsp_ready_i | input | 1 | Read response consumer ready |
| rsp_rdata_o | output | 64 | Read response data |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench builds the block with its default widths:

- a 64-bit status and data word;
- a shift of sixteen;
- a 16-bit mask at bit 32;
- a 4-bit offset.

These values are the ones at which the named status bits land on condition bits 47, 42, 41 and 40. They also place the mask field where the offset-0x8 write data is decoded.

With these widths the bench reaches three corner cases:

- mask bits that are dropped outside 47:32;
- the engine reset colliding with a mask write;
- a held response blocking further requests.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  parameter int OFF_W = 4;

  // Register word offsets; the direction of the access selects the meaning.
  localparam logic [OFF_W-1:0] OFF_MASK   = 4'h8;  // read mask  / write mask
  localparam logic [OFF_W-1:0] OFF_RAW    = 4'h9;  // read raw   / write OR
  localparam logic [OFF_W-1:0] OFF_MASKED = 4'hA;  // read masked/ write AND

  // Named condition bits (position after the shift).
  localparam int COND_BAD_CMD  = 47;
  localparam int COND_NO_ACK   = 42;
  localparam int COND_DATA_REQ = 41;
  localparam int COND_DONE     = 40;

  typedef enum logic [1:0] {
    MOP_LOAD = 2'd0,
    MOP_OR   = 2'd1,
    MOP_AND  = 2'd2
  } mask_op_e;

endpackage

// File: rtl/irqc_mask.sv
module irqc_mask
  import irqc_pkg::*;
#(
  parameter int MW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          eng_clr,
  input  logic          wr_en,
  input  mask_op_e      wr_op,
  input  logic [MW-1:0] wr_val,
  output logic [MW-1:0] mask_q
);

  logic [MW-1:0] mask_d;

  // One update cell per mask bit; the operation picks the bit's next value.
  for (genvar b = 0; b < MW; b++) begin : g_bit
    always_comb begin
      mask_d[b] = mask_q[b];
      if (eng_clr) begin
        mask_d[b] = 1'b0;
      end else if (wr_en) begin
        unique case (wr_op)
          MOP_LOAD: mask_d[b] = wr_val[b];
          MOP_OR:   mask_d[b] = mask_q[b] | wr_val[b];
          MOP_AND:  mask_d[b] = mask_q[b] & wr_val[b];
          default:  mask_d[b] = mask_q[b];
        endcase
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mask_q[b] <= 1'b0;
      else        mask_q[b] <= mask_d[b];
    end
  end

  AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    eng_clr |=> (mask_q == '0)); // R7

  AST_OR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_op == MOP_OR && !eng_clr) |=>
      ((mask_q & $past(wr_val)) == $past(wr_val))); // R5

  AST_AND_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_op == MOP_AND && !eng_clr) |=>
      ((mask_q & ~$past(wr_val)) == '0)); // R6

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !eng_clr) |=> $stable(mask_q)); // R8

endmodule

// File: rtl/irqc_cond.sv
module irqc_cond #(
  parameter int SW    = 64,
  parameter int SHIFT = 16,
  parameter int MW    = 16,
  parameter int MLSB  = 32,
  localparam int RW   = SW - SHIFT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          eng_clr,
  input  logic [SW-1:0] status,
  input  logic [MW-1:0] mask_q,
  output logic [RW-1:0] raw_q,
  output logic [MW-1:0] masked,
  output logic          irq
);

  logic unused_low_status;
  assign unused_low_status = ^status[SHIFT-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       raw_q <= '0;
    else if (eng_clr) raw_q <= '0;
    else              raw_q <= status[SW-1:SHIFT];
  end

  assign masked = raw_q[MLSB +: MW] & mask_q;
  assign irq    = |masked;

  AST_RAW_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    eng_clr |=> (raw_q == '0)); // R7

  AST_RAW_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_clr |=> (raw_q == $past(status[SW-1:SHIFT]))); // R1

endmodule

// File: rtl/irqc_port.sv
module irqc_port
  import irqc_pkg::*;
#(
  parameter int DW   = 64,
  parameter int RW   = 48,
  parameter int MW   = 16,
  parameter int MLSB = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [OFF_W-1:0] req_off,
  input  logic [DW-1:0]    req_wdata,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [DW-1:0]    rsp_rdata,
  input  logic [RW-1:0]    raw_q,
  input  logic [MW-1:0]    masked,
  input  logic [MW-1:0]    mask_q,
  output logic             wr_en,
  output mask_op_e         wr_op,
  output logic [MW-1:0]    wr_val
);

  logic          accept;
  logic [DW-1:0] rd_word;
  logic          unused_wbits;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  assign wr_val       = req_wdata[MLSB +: MW];
  assign unused_wbits = ^{req_wdata[DW-1:MLSB+MW], req_wdata[MLSB-1:0]};

  always_comb begin
    wr_en = 1'b0;
    wr_op = MOP_LOAD;
    if (accept && req_write) begin
      unique case (req_off)
        OFF_MASK:   begin wr_en = 1'b1; wr_op = MOP_LOAD; end
        OFF_RAW:    begin wr_en = 1'b1; wr_op = MOP_OR;   end
        OFF_MASKED: begin wr_en = 1'b1; wr_op = MOP_AND;  end
        default:    wr_en = 1'b0;
      endcase
    end
  end

  always_comb begin
    rd_word = '0;
    unique case (req_off)
      OFF_MASK:   rd_word[MLSB +: MW] = mask_q;
      OFF_RAW:    rd_word[RW-1:0]     = raw_q;
      OFF_MASKED: rd_word[MLSB +: MW] = masked;
      default:    rd_word = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      if (accept && !req_write) begin
        rsp_valid <= 1'b1;
        rsp_rdata <= rd_word;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end

  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata))); // R9

  AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write) |=> rsp_valid); // R9

endmodule

// File: rtl/irq_cond_unit.sv
module irq_cond_unit
  import irqc_pkg::*;
#(
  parameter int SW    = 64,
  parameter int SHIFT = 16,
  parameter int MW    = 16,
  parameter int MLSB  = 32,
  localparam int RW   = SW - SHIFT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             eng_reset_i,
  input  logic [SW-1:0]    status_i,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic             req_write_i,
  input  logic [OFF_W-1:0] req_off_i,
  input  logic [SW-1:0]    req_wdata_i,
  output logic             rsp_valid_o,
  input  logic             rsp_ready_i,
  output logic [SW-1:0]    rsp_rdata_o,
  output logic             irq_o
);

  logic [MW-1:0] mask_q;
  logic [RW-1:0] raw_q;
  logic [MW-1:0] masked;
  logic          wr_en;
  mask_op_e      wr_op;
  logic [MW-1:0] wr_val;

  irqc_mask #(.MW(MW)) u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .eng_clr (eng_reset_i),
    .wr_en   (wr_en),
    .wr_op   (wr_op),
    .wr_val  (wr_val),
    .mask_q  (mask_q)
  );

  irqc_cond #(.SW(SW), .SHIFT(SHIFT), .MW(MW), .MLSB(MLSB)) u_cond (
    .clk     (clk),
    .rst_n   (rst_n),
    .eng_clr (eng_reset_i),
    .status  (status_i),
    .mask_q  (mask_q),
    .raw_q   (raw_q),
    .masked  (masked),
    .irq     (irq_o)
  );

  irqc_port #(.DW(SW), .RW(RW), .MW(MW), .MLSB(MLSB)) u_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid_i),
    .req_ready (req_ready_o),
    .req_write (req_write_i),
    .req_off   (req_off_i),
    .req_wdata (req_wdata_i),
    .rsp_valid (rsp_valid_o),
    .rsp_ready (rsp_ready_i),
    .rsp_rdata (rsp_rdata_o),
    .raw_q     (raw_q),
    .masked    (masked),
    .mask_q    (mask_q),
    .wr_en     (wr_en),
    .wr_op     (wr_op),
    .wr_val    (wr_val)
  );

  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (mask_q != '0)); // R3

  AST_IRQ_NEEDS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (raw_q[MLSB +: MW] != '0)); // R3

  AST_QUIET_AFTER_ENG: assert property (@(posedge clk) disable iff (!rst_n)
    eng_reset_i |=> !irq_o); // R7

  AST_DONE_MAPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!eng_reset_i && status_i[COND_DONE + SHIFT]) |=> raw_q[COND_DONE]); // R11

endmodule

// File: tb/irq_cond_unit_test.sv
module irq_cond_unit_test;

  localparam logic [63:0] MF = 64'h0000_FFFF_0000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        eng_reset_i = 1'b0;
  logic [63:0] status_i = '0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic        req_write_i = 1'b0;
  logic [3:0]  req_off_i = '0;
  logic [63:0] req_wdata_i = '0;
  logic        rsp_valid_o;
  logic        rsp_ready_i = 1'b1;
  logic [63:0] rsp_rdata_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [63:0] m_mask = '0;
  logic [63:0] m_raw = '0;
  logic        m_rspv = 1'b0;
  logic [63:0] m_rspd = '0;
  string       m_tag = "R1";

  always #4 clk = ~clk;

  irq_cond_unit uut (
    .clk(clk), .rst_n(rst_n), .eng_reset_i(eng_reset_i), .status_i(status_i),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o), .req_write_i(req_write_i),
    .req_off_i(req_off_i), .req_wdata_i(req_wdata_i), .rsp_valid_o(rsp_valid_o),
    .rsp_ready_i(rsp_ready_i), .rsp_rdata_o(rsp_rdata_o), .irq_o(irq_o)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [63:0] model_read(input logic [3:0] off);
    case (off)
      4'h8:    return m_mask;
      4'h9:    return m_raw;
      4'hA:    return m_raw & m_mask;
      default: return 64'h0;
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] off);
    case (off)
      4'h8:    return "R4";
      4'h9:    return "R1";
      4'hA:    return "R2";
      default: return "R8";
    endcase
  endfunction

  // Drive one cycle at a falling edge, advance the model, compare after the rising edge.
  task automatic step(input bit v, input bit w, input logic [3:0] off,
                      input logic [63:0] wd, input logic [63:0] st,
                      input bit er, input bit rr);
    bit exp_ready, acc, n_rspv;
    logic [63:0] n_rspd;
    req_valid_i = v; req_write_i = w; req_off_i = off; req_wdata_i = wd;
    status_i = st; eng_reset_i = er; rsp_ready_i = rr;
    #1;
    exp_ready = !m_rspv || rr;
    chk(req_ready_o === exp_ready, "R9", "req_ready", 64'(req_ready_o), 64'(exp_ready));
    acc = v && exp_ready;
    n_rspv = m_rspv; n_rspd = m_rspd;
    if (m_rspv && rr) n_rspv = 1'b0;
    if (acc && !w) begin
      n_rspv = 1'b1; n_rspd = model_read(off); m_tag = tag_of(off);
    end
    if (er) begin
      m_mask = '0; m_raw = '0;
    end else begin
      m_raw = st >> 16;
      if (acc && w) begin
        case (off)
          4'h8: m_mask = wd & MF;
          4'h9: m_mask = m_mask | (wd & MF);
          4'hA: m_mask = m_mask & (wd & MF);
          default: ;
        endcase
      end
    end
    m_rspv = n_rspv; m_rspd = n_rspd;
    @(posedge clk); #2;
    chk(irq_o === ((m_raw & m_mask) != 0), "R3", "irq", 64'(irq_o),
        64'((m_raw & m_mask) != 0));
    chk(rsp_valid_o === m_rspv, "R9", "rsp_valid", 64'(rsp_valid_o), 64'(m_rspv));
    if (m_rspv) chk(rsp_rdata_o === m_rspd, m_tag, "rsp_data", rsp_rdata_o, m_rspd);
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] off, input logic [63:0] wd, input logic [63:0] st);
    step(1'b1, 1'b1, off, wd, st, 1'b0, 1'b1);
  endtask

  task automatic rd(input logic [3:0] off, input logic [63:0] st);
    step(1'b1, 1'b0, off, 64'h0, st, 1'b0, 1'b1);
  endtask

  task automatic expect_rsp(input string tag, input logic [63:0] exp);
    chk(rsp_valid_o === 1'b1 && rsp_rdata_o === exp, tag, "read value", rsp_rdata_o, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] st;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(irq_o === 1'b0, "R10", "irq after reset", 64'(irq_o), 64'h0);
    chk(rsp_valid_o === 1'b0, "R10", "rsp_valid after reset", 64'(rsp_valid_o), 64'h0);
    chk(req_ready_o === 1'b1, "R10", "req_ready after reset", 64'(req_ready_o), 64'h1);
    @(negedge clk);
    rd(4'h8, 64'h0);
    expect_rsp("R10", 64'h0);

    // R4: load drops bits outside the mask field
    wr(4'h8, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0);
    rd(4'h8, 64'h0);
    expect_rsp("R4", MF);

    // R11: named status bits land on condition bits 40/41/42/47
    st = (64'h1 << 56) | (64'h1 << 63);
    step(1'b0, 1'b0, 4'h0, 64'h0, st, 1'b0, 1'b1);
    rd(4'h9, st);
    expect_rsp("R11", (64'h1 << 40) | (64'h1 << 47));
    st = (64'h1 << 57) | (64'h1 << 58);
    step(1'b0, 1'b0, 4'h0, 64'h0, st, 1'b0, 1'b1);
    rd(4'h9, st);
    expect_rsp("R11", (64'h1 << 41) | (64'h1 << 42));
    chk(irq_o === 1'b1, "R3", "irq with named bits", 64'(irq_o), 64'h1);

    // R1: low status bits shift down
    st = 64'h0000_0000_1234_5678;
    step(1'b0, 1'b0, 4'h0, 64'h0, st, 1'b0, 1'b1);
    rd(4'h9, st);
    expect_rsp("R1", 64'h0000_0000_0000_1234);
    chk(irq_o === 1'b0, "R3", "irq with only low conditions", 64'(irq_o), 64'h0);

    // R5 / R6: OR and AND aliases
    wr(4'h8, 64'h0000_0001_0000_0000, 64'h0);
    wr(4'h9, 64'h0000_0100_0000_0000, 64'h0);
    rd(4'h8, 64'h0);
    expect_rsp("R5", 64'h0000_0101_0000_0000);
    wr(4'hA, 64'hFFFF_0001_FFFF_FFFF, 64'h0);
    rd(4'h8, 64'h0);
    expect_rsp("R6", 64'h0000_0001_0000_0000);

    // R3 / R2: masked view and interrupt level
    st = 64'h0003_0000_0000_0000;
    step(1'b0, 1'b0, 4'h0, 64'h0, st, 1'b0, 1'b1);
    chk(irq_o === 1'b1, "R3", "irq on enabled condition", 64'(irq_o), 64'h1);
    rd(4'hA, st);
    expect_rsp("R2", 64'h0000_0001_0000_0000);
    wr(4'hA, 64'h0, st);
    chk(irq_o === 1'b0, "R3", "irq after mask cleared", 64'(irq_o), 64'h0);

    // R8: unlisted offsets
    wr(4'h8, 64'h0000_00F0_0000_0000, st);
    wr(4'h3, 64'hFFFF_FFFF_FFFF_FFFF, st);
    wr(4'hB, 64'h0, st);
    rd(4'h8, st);
    expect_rsp("R8", 64'h0000_00F0_0000_0000);
    rd(4'h3, st);
    expect_rsp("R8", 64'h0);

    // R7: engine reset beats a same-cycle write
    step(1'b1, 1'b1, 4'h9, 64'hFFFF_FFFF_FFFF_FFFF, st, 1'b1, 1'b1);
    chk(irq_o === 1'b0, "R7", "irq after engine reset", 64'(irq_o), 64'h0);
    rd(4'h9, st);
    expect_rsp("R7", 64'h0);
    rd(4'h8, st);
    expect_rsp("R7", 64'h0);

    // R9: held response blocks requests
    rd(4'h9, st);
    step(1'b1, 1'b0, 4'h9, 64'h0, 64'h0, 1'b0, 1'b0);
    step(1'b1, 1'b0, 4'h8, 64'h0, 64'h0, 1'b0, 1'b0);
    chk(req_ready_o === 1'b0, "R9", "ready while held", 64'(req_ready_o), 64'h0);
    expect_rsp("R9", st >> 16);
    step(1'b0, 1'b0, 4'h0, 64'h0, 64'h0, 1'b0, 1'b1);
    chk(rsp_valid_o === 1'b0, "R9", "drained", 64'(rsp_valid_o), 64'h0);
    wr(4'h8, MF, 64'h0);
    chk(rsp_valid_o === 1'b0, "R9", "write gives no response", 64'(rsp_valid_o), 64'h0);

    // Random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] off;
      logic [63:0] s;
      case ($urandom % 4)
        0: off = 4'h8;
        1: off = 4'h9;
        2: off = 4'hA;
        default: off = 4'($urandom);
      endcase
      s = ($urandom % 3 == 0) ? 64'h0 : {$urandom, $urandom};
      step(($urandom % 3) != 0, ($urandom % 2) == 1, off, {$urandom, $urandom}, s,
           ($urandom % 40) == 0, ($urandom % 4) != 0);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule